// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This block keeps wall-clock time and calendar date in packed BCD registers and advances them by one second on each cycle in which the one-pulse-per-second enable `pps` is high. It counts seconds, minutes and hours, and has a 12-hour mode with a PM flag. It also counts day of week, date with month lengths and leap years, month, and a two-digit year. Bytes that a host reads as plain BCD also carry flags: a halt bit sits above the seconds, and the mode and PM bits sit above the hour digits.

A byte-wide register port with a 6-bit index gives access to the time fields, a control byte and a bank of general-purpose RAM that fills the rest of the index space. Reads are combinational from the index. A write is taken on any clock edge with `wr_en` high. The port has no back-pressure, so a write can never be stalled. Every other pin is plain control or status.

The control byte drives `sqw_out`. It either holds a static level or gives a square wave at 1 Hz, 4096 Hz, 8192 Hz or 32768 Hz. The square wave comes from a divider that counts rising edges of the 32768 Hz level input `osc32_lvl`.

Top module: `rtc_bcd_core`

## Requirements
- R1: Index 0 holds seconds in BCD in bits 6:0 and a halt flag in bit 7. A `pps` pulse advances the seconds while the halt flag is 0. While the halt flag is 1, the seconds and all higher fields keep their value.
- R2: Seconds wrap from 59 to 00 and carry into minutes (index 1, bits 6:0). Minutes wrap from 59 to 00 and carry into hours. In 24-hour mode (index 2, bit 6 = 0, hour in bits 5:0) the hour wraps from 23 to 00 and carries into the day.
- R3: In 12-hour mode (index 2, bit 6 = 1), the hour is in bits 4:0 and bit 5 = 1 means PM. An hour of 11 steps to 12 and toggles bit 5. An hour of 12 steps to 01 with bit 5 unchanged. The day carry happens only when 11 PM steps to 12 AM.
- R4: Day of week (index 3, bits 2:0) steps 1 to 7 on each day carry, and wraps from 7 to 1.
- R5: Date (index 4, bits 5:0) wraps to 01 and carries into the month after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. For 02 it is 29 when the BCD year (index 6) is divisible by 4, and 28 otherwise.
- R6: Month (index 5, bits 4:0) wraps from 12 to 01 and carries into the year. The year (index 6, all 8 bits BCD) wraps from 99 to 00.
- R7: Bits outside a field read 0. These are index 1 bit 7, index 2 bit 7, index 3 bits 7:3, index 4 bits 7:6, index 5 bits 7:5, and index 7 bits 6, 5, 3 and 2.
- R8: Indices 0x08 to 0x3F are RAM bytes that read back what was last written there. Writing them changes no time or control field.
- R9: Index 7 is control: bit 7 is the static level, bit 4 is the wave enable, and bits 1:0 select the rate. When bit 4 is 0, `sqw_out` equals bit 7 whatever the rate.
- R10: When bit 4 is 1, the rate code picks the output. Code 00 gives divider bit 14 (1 Hz). Code 01 gives divider bit 2 (4096 Hz). Code 10 gives divider bit 1 (8192 Hz). Code 11 passes `osc32_lvl` straight through. The divider increments on every clock edge where `osc32_lvl` is 1 and was 0 on the previous edge.
- R11: A write to index 0 clears the divider to zero.
- R12: After reset the time is 00:00:00 in 24-hour mode with the halt flag 0. Day, date and month all read 01, the year reads 00, and control reads 0x00, so `sqw_out` is 0.
- R13: A write to any of indices 0 to 6 in the same cycle as `pps` wins. The written value is stored and no field advances in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps | input | 1 | One-cycle pulse once per second; advances the time |
| osc32_lvl | input | 1 | 32768 Hz square-wave level, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register index for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| sqw_out | output | 1 | Square-wave or static-level output |

## Verification
Read data depends on `addr` in the same cycle, so a read is due as soon as the index is applied. A write or a `pps` step is visible on `rd_data` in the cycle after the edge that takes it. The divider taps change in the cycle after the edge that sees a rising `osc32_lvl`, while rate code 11 follows `osc32_lvl` with no register in the path. The bench drives every input just after a falling edge. It samples one nanosecond later, before the next rising edge, so each sample sees exactly the edges the requirement counts.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic       halt;
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hr;    // bit 6 mode, bit 5 PM or tens, bits 4:0 digits
    logic [2:0] wday;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
  } cal_t;

  // Two-digit packed BCD increment, no range wrap
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day of a month as packed BCD
  function automatic logic [5:0] month_end(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pps,
  input  logic       we,
  input  logic [2:0] idx,
  input  logic [7:0] wdata,
  output cal_t       tq
);
  cal_t       nxt;
  logic       c_min, c_hr, c_day, c_mon, c_yr, leap, step;
  logic [7:0] s_inc, m_inc, h_inc, d_inc, mo_inc, y_inc;

  assign step  = pps && !tq.halt && !we;
  // BCD year mod 4 equals (2*tens + units) mod 4
  assign leap  = (2'({tq.yr[4], 1'b0}) + tq.yr[1:0]) == 2'b00;
  assign s_inc  = bcd_inc({1'b0, tq.sec});
  assign m_inc  = bcd_inc({1'b0, tq.min});
  assign h_inc  = bcd_inc({2'b00, tq.hr[6] ? {1'b0, tq.hr[4:0]} : tq.hr[5:0]});
  assign d_inc  = bcd_inc({2'b00, tq.date});
  assign mo_inc = bcd_inc({3'b000, tq.mon});
  assign y_inc  = bcd_inc(tq.yr);

  always_comb begin
    nxt   = tq;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    if (tq.sec == 7'h59) begin nxt.sec = 7'h00; c_min = 1'b1; end
    else nxt.sec = s_inc[6:0];
    if (c_min) begin
      if (tq.min == 7'h59) begin nxt.min = 7'h00; c_hr = 1'b1; end
      else nxt.min = m_inc[6:0];
    end
    if (c_hr) begin
      if (tq.hr[6]) begin
        if (tq.hr[4:0] == 5'h11) begin
          nxt.hr = {1'b1, ~tq.hr[5], 5'h12};
          c_day  = tq.hr[5];
        end else if (tq.hr[4:0] == 5'h12) nxt.hr = {1'b1, tq.hr[5], 5'h01};
        else nxt.hr = {1'b1, tq.hr[5], h_inc[4:0]};
      end else if (tq.hr[5:0] == 6'h23) begin
        nxt.hr = 7'h00; c_day = 1'b1;
      end else nxt.hr = {1'b0, h_inc[5:0]};
    end
    if (c_day) begin
      nxt.wday = (tq.wday == 3'd7) ? 3'd1 : tq.wday + 3'd1;
      if (tq.date == month_end(tq.mon, leap)) begin nxt.date = 6'h01; c_mon = 1'b1; end
      else nxt.date = d_inc[5:0];
    end
    if (c_mon) begin
      if (tq.mon == 5'h12) begin nxt.mon = 5'h01; c_yr = 1'b1; end
      else nxt.mon = mo_inc[4:0];
    end
    if (c_yr) nxt.yr = (tq.yr == 8'h99) ? 8'h00 : y_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tq <= '{halt: 1'b0, sec: 7'h00, min: 7'h00, hr: 7'h00,
              wday: 3'd1, date: 6'h01, mon: 5'h01, yr: 8'h00};
    end else if (we) begin
      case (idx)
        3'd0: begin tq.halt <= wdata[7]; tq.sec <= wdata[6:0]; end
        3'd1: tq.min  <= wdata[6:0];
        3'd2: tq.hr   <= wdata[6:0];
        3'd3: tq.wday <= wdata[2:0];
        3'd4: tq.date <= wdata[5:0];
        3'd5: tq.mon  <= wdata[4:0];
        3'd6: tq.yr   <= wdata;
        default: ;
      endcase
    end else if (step) begin
      tq <= nxt;
    end
  end
endmodule

// File: rtl/rtc_sqw_gen.sv
module rtc_sqw_gen #(
  parameter int OSC_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_lvl,
  input  logic       clr,
  input  logic       en,
  input  logic       static_lvl,
  input  logic [1:0] rate,
  output logic       sqw
);
  localparam int DIV_W    = $clog2(OSC_HZ);
  localparam int TAP_SLOW = DIV_W - 1;
  localparam int TAP_4K   = 2;
  localparam int TAP_8K   = 1;

  logic [DIV_W-1:0] div_q;
  logic             osc_prev, wave;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      osc_prev <= 1'b0;
    end else begin
      osc_prev <= osc_lvl;
      if (clr)                       div_q <= '0;
      else if (osc_lvl && !osc_prev) div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    case (rate)
      2'b00:   wave = div_q[TAP_SLOW];
      2'b01:   wave = div_q[TAP_4K];
      2'b10:   wave = div_q[TAP_8K];
      default: wave = osc_lvl;
    endcase
  end

  assign sqw = en ? wave : static_lvl;
endmodule

// File: rtl/rtc_gp_ram.sv
module rtc_gp_ram #(
  parameter int ADDR_W = 6,
  parameter int BASE   = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = (1 << ADDR_W) - BASE;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] slot;

  assign slot  = addr - ADDR_W'(BASE);
  assign rdata = mem[slot];

  always_ff @(posedge clk) begin
    if (we) mem[slot] <= wdata;
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int OSC_HZ = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps,
  input  logic              osc32_lvl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              sqw_out
);
  localparam int CAL_REGS = 7;
  localparam int CTRL_IDX = 7;
  localparam int RAM_BASE = 8;

  cal_t       tq;
  logic       time_we, ctrl_we, ram_we;
  logic       out_lvl_q, wave_en_q;
  logic [1:0] rate_q;
  logic [7:0] ram_rd;

  assign time_we = wr_en && (addr <  ADDR_W'(CAL_REGS));
  assign ctrl_we = wr_en && (addr == ADDR_W'(CTRL_IDX));
  assign ram_we  = wr_en && (addr >= ADDR_W'(RAM_BASE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_lvl_q <= 1'b0;
      wave_en_q <= 1'b0;
      rate_q    <= 2'b00;
    end else if (ctrl_we) begin
      out_lvl_q <= wr_data[7];
      wave_en_q <= wr_data[4];
      rate_q    <= wr_data[1:0];
    end
  end

  rtc_timekeep u_time (
    .clk   (clk),
    .rst_n (rst_n),
    .pps   (pps),
    .we    (time_we),
    .idx   (addr[2:0]),
    .wdata (wr_data),
    .tq    (tq)
  );

  rtc_sqw_gen #(.OSC_HZ(OSC_HZ)) u_sqw (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_lvl    (osc32_lvl),
    .clr        (time_we && addr[2:0] == 3'd0),
    .en         (wave_en_q),
    .static_lvl (out_lvl_q),
    .rate       (rate_q),
    .sqw        (sqw_out)
  );

  rtc_gp_ram #(.ADDR_W(ADDR_W), .BASE(RAM_BASE)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (addr),
    .wdata (wr_data),
    .rdata (ram_rd)
  );

  always_comb begin
    case (addr)
      ADDR_W'(0): rd_data = {tq.halt, tq.sec};
      ADDR_W'(1): rd_data = {1'b0, tq.min};
      ADDR_W'(2): rd_data = {1'b0, tq.hr};
      ADDR_W'(3): rd_data = {5'b0, tq.wday};
      ADDR_W'(4): rd_data = {2'b0, tq.date};
      ADDR_W'(5): rd_data = {3'b0, tq.mon};
      ADDR_W'(6): rd_data = tq.yr;
      ADDR_W'(7): rd_data = {out_lvl_q, 2'b00, wave_en_q, 2'b00, rate_q};
      default:    rd_data = ram_rd;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pps,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              sqw_out
);
  // R1
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(0) && rd_data[7] && !wr_en) ##1 (addr == ADDR_W'(0))
      |-> rd_data == $past(rd_data));

  // R1
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(0) && pps && !wr_en && !rd_data[7] && rd_data[3:0] < 4'd9)
      ##1 (addr == ADDR_W'(0))
      |-> rd_data[3:0] == $past(rd_data[3:0]) + 4'd1);

  // R7
  wday_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(3)) |-> rd_data[7:3] == 5'd0);

  // R7
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(7)) |-> (rd_data[6:5] == 2'b00 && rd_data[3:2] == 2'b00));

  // R8
  ram_rdback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= ADDR_W'(8)) ##1 (!wr_en && addr == $past(addr))
      |-> rd_data == $past(wr_data));

  // R9
  static_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(7) && !rd_data[4]) |-> sqw_out == rd_data[7]);
endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pps     (pps),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .sqw_out (sqw_out)
);

// File: tb/rtc_bcd_core_tb.sv
module rtc_bcd_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pps = 1'b0;
  logic       osc32_lvl = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sqw_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rtc_bcd_core u_dut (
    .clk(clk), .rst_n(rst_n), .pps(pps), .osc32_lvl(osc32_lvl),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sqw_out(sqw_out)
  );

  // {sec,min,hr,wday,date,mon,yr} before one pps, then expected after
  localparam int NV = 13;
  localparam logic [111:0] VEC [NV] = '{
    112'h10_00_00_03_15_06_24_11_00_00_03_15_06_24, // R1 plain step
    112'h59_09_05_03_15_06_24_00_10_05_03_15_06_24, // R2 minute carry
    112'h59_59_19_02_31_03_25_00_00_20_02_31_03_25, // R2 hour carry
    112'h59_59_23_07_31_12_99_00_00_00_01_01_01_00, // R4 R6 full wrap
    112'h59_59_23_02_28_02_23_00_00_00_03_01_03_23, // R5 short Feb
    112'h59_59_23_02_28_02_24_00_00_00_03_29_02_24, // R5 leap Feb
    112'h59_59_23_01_28_02_00_00_00_00_02_29_02_00, // R5 year 00 leap
    112'h59_59_23_04_29_02_24_00_00_00_05_01_03_24, // R5 leap end
    112'h59_59_23_01_30_04_25_00_00_00_02_01_05_25, // R5 30-day month
    112'h59_59_23_06_31_01_25_00_00_00_07_01_02_25, // R5 R6 31-day month
    112'h59_59_51_04_10_05_25_00_00_72_04_10_05_25, // R3 11AM to 12PM
    112'h59_59_71_05_10_05_25_00_00_52_06_11_05_25, // R3 11PM to 12AM
    112'h59_59_72_05_10_05_25_00_00_61_05_10_05_25  // R3 12PM to 1PM
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_with_pps(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1; pps = 1'b1;
    @(negedge clk); wr_en = 1'b0; pps = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rd_data;
  endtask

  task automatic tick_pps();
    @(negedge clk); pps = 1'b1;
    @(negedge clk); pps = 1'b0;
  endtask

  task automatic osc_edges(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); osc32_lvl = 1'b1;
      @(negedge clk); osc32_lvl = 1'b0;
    end
    #1;
  endtask

  task automatic chk_rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [111:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk_rd("R12 sec", 6'd0, 8'h00);
    chk_rd("R12 hr", 6'd2, 8'h00);
    chk_rd("R12 wday", 6'd3, 8'h01);
    chk_rd("R12 date", 6'd4, 8'h01);
    chk_rd("R12 mon", 6'd5, 8'h01);
    chk_rd("R12 yr", 6'd6, 8'h00);
    chk_rd("R12 ctrl", 6'd7, 8'h00);
    check("R12 sqw", {7'd0, sqw_out}, 8'h00);

    // Vector table: load, one pps, compare all seven fields
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      for (int j = 0; j < 7; j++) wr(6'(j), v[111 - 8*j -: 8]);
      tick_pps();
      for (int j = 0; j < 7; j++)
        chk_rd($sformatf("R2-chain vec%0d reg%0d", i, j), 6'(j), v[55 - 8*j -: 8]);
    end

    // R13 write beats a same-cycle pps
    wr_with_pps(6'd0, 8'h20);
    chk_rd("R13 write wins", 6'd0, 8'h20);
    wr_with_pps(6'd6, 8'h42);
    chk_rd("R13 sec untouched", 6'd0, 8'h20);
    tick_pps();
    chk_rd("R1 step", 6'd0, 8'h21);

    // R1 halt
    wr(6'd0, 8'hB0);
    tick_pps();
    chk_rd("R1 halted", 6'd0, 8'hB0);
    wr(6'd0, 8'h30);
    tick_pps();
    chk_rd("R1 resumed", 6'd0, 8'h31);

    // R7 field masks
    wr(6'd1, 8'hFF); chk_rd("R7 min", 6'd1, 8'h7F);
    wr(6'd3, 8'hFF); chk_rd("R7 wday", 6'd3, 8'h07);
    wr(6'd4, 8'hFF); chk_rd("R7 date", 6'd4, 8'h3F);
    wr(6'd5, 8'hFF); chk_rd("R7 mon", 6'd5, 8'h1F);
    wr(6'd7, 8'hFF); chk_rd("R7 ctrl", 6'd7, 8'h93);

    // R10 rate 11 passes the oscillator level
    @(negedge clk); osc32_lvl = 1'b1; #1;
    check("R10 pass high", {7'd0, sqw_out}, 8'h01);
    @(negedge clk); osc32_lvl = 1'b0; #1;
    check("R10 pass low", {7'd0, sqw_out}, 8'h00);

    // R9 static level when wave disabled
    wr(6'd7, 8'h80); #1; check("R9 out high", {7'd0, sqw_out}, 8'h01);
    wr(6'd7, 8'h00); #1; check("R9 out low", {7'd0, sqw_out}, 8'h00);
    wr(6'd7, 8'h83); #1; check("R9 rate ignored", {7'd0, sqw_out}, 8'h01);

    // R10 8192 Hz tap (divider bit 1), R11 clear by seconds write
    wr(6'd7, 8'h12);
    wr(6'd0, 8'h00);
    osc_edges(1); check("R10 8k n1", {7'd0, sqw_out}, 8'h00);
    osc_edges(1); check("R10 8k n2", {7'd0, sqw_out}, 8'h01);
    osc_edges(1); check("R10 8k n3", {7'd0, sqw_out}, 8'h01);
    osc_edges(1); check("R10 8k n4", {7'd0, sqw_out}, 8'h00);
    osc_edges(3); check("R10 8k n7", {7'd0, sqw_out}, 8'h01);
    wr(6'd0, 8'h00); #1;
    check("R11 cleared", {7'd0, sqw_out}, 8'h00);
    osc_edges(1); check("R11 after n1", {7'd0, sqw_out}, 8'h00);
    osc_edges(1); check("R11 after n2", {7'd0, sqw_out}, 8'h01);

    // R10 4096 Hz tap (divider bit 2)
    wr(6'd7, 8'h11);
    wr(6'd0, 8'h00);
    osc_edges(3); check("R10 4k n3", {7'd0, sqw_out}, 8'h00);
    osc_edges(1); check("R10 4k n4", {7'd0, sqw_out}, 8'h01);

    // R10 1 Hz tap (divider bit 14)
    wr(6'd7, 8'h10);
    wr(6'd0, 8'h00);
    osc_edges(16383); check("R10 1Hz n16383", {7'd0, sqw_out}, 8'h00);
    osc_edges(1);     check("R10 1Hz n16384", {7'd0, sqw_out}, 8'h01);

    // R8 RAM bytes
    wr(6'h08, 8'hA5);
    wr(6'h3F, 8'h5A);
    wr(6'h20, 8'h3C);
    chk_rd("R8 low", 6'h08, 8'hA5);
    chk_rd("R8 top", 6'h3F, 8'h5A);
    chk_rd("R8 mid", 6'h20, 8'h3C);
    chk_rd("R8 sec untouched", 6'd0, 8'h00);
    chk_rd("R8 ctrl untouched", 6'd7, 8'h10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule